// File: doc/BRIEF.md
# MMC Command-Line Special Sequence Generator

This block owns the single command line of an MMC/SD host while the host is in one of its special signalling modes. It does not send normal command frames. It produces three patterns:

- a card initialization stream, in which the line is held high for a fixed number of card clocks;
- a completion-signal-disable token for CE-ATA devices, which is a long forced-low run followed by a high bit;
- a 48-bit response-format frame that the host sends in place of a command.

An open-drain option changes how the line is driven. With it set, the driver only pulls the line low and lets the external pull-up supply every 1.

The host register logic supplies four level control bits (init, host-response, CE-ATA, open-drain), the 32-bit argument, and a command-register write strobe with its data. The card clock divider supplies a one-cycle enable. The line moves by one bit only on cycles where that enable is high.

When a sequence finishes, the block raises a one-cycle command-complete pulse, which the status logic latches. While a sequence runs, the block reports busy and ignores new requests.

State machine:
- States: `ST_IDLE`, `ST_INIT`, `ST_TOK_LOW`, `ST_TOK_HIGH` and `ST_RESP`.
- Transitions out of idle: IDLE→INIT on an init request (this has priority). IDLE→TOK_LOW on a qualifying all-zero command write. IDLE→RESP on a host-response command write.
- Transitions between states: TOK_LOW→TOK_HIGH after 47 bits.
- Transitions back to idle: INIT→IDLE after 80 bits, TOK_HIGH→IDLE after 1 bit, and RESP→IDLE after 48 bits. Each return to idle raises command-complete.

Top module: `mmc_cmdline_seq`

## Requirements
- R1: After reset the block is idle. `line_oe`=0, `line_o`=1, `busy`=0 and `cmd_done`=0. Whenever `busy` is 0, `line_oe` is 0 and `line_o` is 1.
- R2: A 0→1 change of `cfg_init` while idle starts an initialization stream. The resolved line is 1 for exactly 80 card-clock-enable cycles, and no other bit is sent.
- R3: `cmd_done` is high for exactly one cycle, in the cycle after the last bit of a sequence is consumed. In that cycle `busy` is 0. `busy` is 1 from the first driven cycle up to that cycle.
- R4: A `cmd_wr` with `cmd_wdata`=0, `arg_in`=0, `cfg_ceata`=1 and `cfg_host_resp`=1 sends the disable token: 47 bits of 0, then one bit of 1.
- R5: A `cmd_wr` with `cfg_host_resp`=1 and `cfg_ceata`=0 sends a 48-bit frame, MSB first. The frame is, in order: a start bit 0, a direction bit 0, the 6-bit index `cmd_wdata[5:0]`, the 32-bit `arg_in`, a 7-bit CRC and an end bit 1.
- R6: The frame CRC is CRC7 with polynomial x^7+x^3+1 and zero seed, computed over the first 40 frame bits.
- R7: With `cfg_open_drain`=1, a 1 is sent with `line_oe`=0 and a 0 with `line_oe`=1 and `line_o`=0. With `cfg_open_drain`=0, every bit of a sequence is driven with `line_oe`=1.
- R8: An init edge or a command write that arrives while `busy` is 1 is ignored. The running sequence is unchanged and no second sequence follows.
- R9: The line changes only on cycles that follow an asserted `card_ce`. Each bit lasts one enable period.
- R10: These command writes start nothing: any write with `cfg_host_resp`=0, and a write with `cfg_ceata`=1 whose data or argument is nonzero.
- R11: If an init edge and a starting command write arrive in the same idle cycle, only the initialization stream is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_ce | input | 1 | One-cycle card clock enable; one line bit per assertion |
| cfg_init | input | 1 | Init-stream request bit; a 0→1 edge starts the stream |
| cfg_host_resp | input | 1 | Host-response mode bit |
| cfg_ceata | input | 1 | CE-ATA mode bit |
| cfg_open_drain | input | 1 | Open-drain drive bit |
| arg_in | input | 32 | Argument register value |
| cmd_wr | input | 1 | Command-register write strobe |
| cmd_wdata | input | 16 | Command-register write data |
| line_o | output | 1 | Command line output value |
| line_oe | output | 1 | Command line output enable |
| busy | output | 1 | A sequence is in progress |
| cmd_done | output | 1 | One-cycle command-complete pulse |

## Verification
The hardest situation to reach is a collision: a request arriving in the middle of a running sequence, or two requests arriving in the same idle cycle. Only one of them may take effect, and the other must leave no trace, not even a delayed second sequence.

The bench reaches these cases by raising the init bit and pulsing a host-response command write several enable periods into a running stream. It also raises both in one cycle while idle. The scoreboard then requires exactly the bits of the winning sequence, followed by an idle, released line.

A slow card clock enable, with a period of three or four cycles, keeps each bit on the line long enough that the hold between enables is also checked.

// File: rtl/mmc_seq_pkg.sv
package mmc_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_TOK_LOW,
        ST_TOK_HIGH,
        ST_RESP
    } seq_state_t;

    localparam logic [6:0] CRC7_POLY = 7'h09;
endpackage

// File: rtl/mmc_seq_crc7.sv
module mmc_seq_crc7 #(
    parameter int DATA_W = 40
) (
    input  logic [DATA_W-1:0] data,
    output logic [6:0]        crc
);
    import mmc_seq_pkg::*;

    always_comb begin
        logic [6:0] c;
        logic       fb;
        c = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = data[i] ^ c[6];
            c  = {c[5:0], 1'b0};
            if (fb) begin
                c = c ^ CRC7_POLY;
            end
        end
        crc = c;
    end
endmodule

// File: rtl/mmc_seq_frame.sv
module mmc_seq_frame #(
    parameter int IDX_W = 6,
    parameter int ARG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [IDX_W-1:0] idx,
    input  logic [ARG_W-1:0] arg,
    output logic             msb
);
    localparam int HEAD_W  = 2 + IDX_W + ARG_W;
    localparam int FRAME_W = HEAD_W + 7 + 1;

    logic [HEAD_W-1:0]  head;
    logic [6:0]         crc;
    logic [FRAME_W-1:0] frame_q;

    assign head = {1'b0, 1'b0, idx, arg};

    mmc_seq_crc7 #(.DATA_W(HEAD_W)) u_crc (
        .data (head),
        .crc  (crc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '1;
        end else if (load) begin
            frame_q <= {head, crc, 1'b1};
        end else if (shift) begin
            frame_q <= {frame_q[FRAME_W-2:0], 1'b1};
        end
    end

    assign msb = frame_q[FRAME_W-1];
endmodule

// File: rtl/mmc_seq_drive.sv
module mmc_seq_drive (
    input  logic active,
    input  logic bit_val,
    input  logic od,
    output logic line_o,
    output logic line_oe
);
    always_comb begin
        if (!active) begin
            line_o  = 1'b1;
            line_oe = 1'b0;
        end else begin
            line_o  = bit_val;
            line_oe = od ? ~bit_val : 1'b1;
        end
    end
endmodule

// File: rtl/mmc_cmdline_seq.sv
module mmc_cmdline_seq #(
    parameter int ARG_W         = 32,
    parameter int CMDW_W        = 16,
    parameter int IDX_W         = 6,
    parameter int INIT_BITS     = 80,
    parameter int TOK_LOW_BITS  = 47,
    parameter int TOK_HIGH_BITS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_ce,
    input  logic              cfg_init,
    input  logic              cfg_host_resp,
    input  logic              cfg_ceata,
    input  logic              cfg_open_drain,
    input  logic [ARG_W-1:0]  arg_in,
    input  logic              cmd_wr,
    input  logic [CMDW_W-1:0] cmd_wdata,
    output logic              line_o,
    output logic              line_oe,
    output logic              busy,
    output logic              cmd_done
);
    import mmc_seq_pkg::*;

    localparam int FRAME_W = 2 + IDX_W + ARG_W + 7 + 1;
    localparam int MAX_A   = (INIT_BITS > FRAME_W) ? INIT_BITS : FRAME_W;
    localparam int MAX_LEN = (MAX_A > TOK_LOW_BITS) ? MAX_A : TOK_LOW_BITS;
    localparam int CNT_W   = $clog2(MAX_LEN);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             init_q;
    logic             done_q, done_d;
    logic             init_req, tok_req, resp_req;
    logic             frame_load, frame_shift, frame_msb;
    logic             cur_bit, active;

    // Request decode: an init edge has priority over a command write (R11)
    assign init_req = cfg_init & ~init_q;
    assign tok_req  = cmd_wr & cfg_host_resp & cfg_ceata &
                      (arg_in == '0) & (cmd_wdata == '0);
    assign resp_req = cmd_wr & cfg_host_resp & ~cfg_ceata;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        done_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (init_req) begin
                    state_d = ST_INIT;
                    cnt_d   = CNT_W'(INIT_BITS - 1);
                end else if (tok_req) begin
                    state_d = ST_TOK_LOW;
                    cnt_d   = CNT_W'(TOK_LOW_BITS - 1);
                end else if (resp_req) begin
                    state_d = ST_RESP;
                    cnt_d   = CNT_W'(FRAME_W - 1);
                end
            end
            ST_INIT, ST_TOK_HIGH, ST_RESP: begin
                if (card_ce) begin
                    if (cnt_q == '0) begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            ST_TOK_LOW: begin
                if (card_ce) begin
                    if (cnt_q == '0) begin
                        state_d = ST_TOK_HIGH;
                        cnt_d   = CNT_W'(TOK_HIGH_BITS - 1);
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            init_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            init_q  <= cfg_init;
            done_q  <= done_d;
        end
    end

    assign frame_load  = (state_q == ST_IDLE) & resp_req & ~init_req & ~tok_req;
    assign frame_shift = (state_q == ST_RESP) & card_ce;

    mmc_seq_frame #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (frame_load),
        .shift (frame_shift),
        .idx   (cmd_wdata[IDX_W-1:0]),
        .arg   (arg_in),
        .msb   (frame_msb)
    );

    // Output decode
    always_comb begin
        active  = 1'b1;
        cur_bit = 1'b1;
        unique case (state_q)
            ST_IDLE:     active  = 1'b0;
            ST_INIT:     cur_bit = 1'b1;
            ST_TOK_LOW:  cur_bit = 1'b0;
            ST_TOK_HIGH: cur_bit = 1'b1;
            ST_RESP:     cur_bit = frame_msb;
            default:     active  = 1'b0;
        endcase
    end

    mmc_seq_drive u_drive (
        .active  (active),
        .bit_val (cur_bit),
        .od      (cfg_open_drain),
        .line_o  (line_o),
        .line_oe (line_oe)
    );

    assign busy     = active;
    assign cmd_done = done_q;
endmodule

// File: rtl/mmc_seq_chk.sv
module mmc_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic card_ce,
    input logic cfg_open_drain,
    input logic line_o,
    input logic line_oe,
    input logic busy,
    input logic cmd_done
);
    assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!line_oe && line_o));

    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> !busy);

    assert_busy_end_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> cmd_done);

    assert_od_low_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open_drain && line_oe) |-> !line_o);

    assert_pp_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cfg_open_drain) |-> line_oe);

    assert_hold_no_ce_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(card_ce)) |-> $stable(line_o));
endmodule

bind mmc_cmdline_seq mmc_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .card_ce        (card_ce),
    .cfg_open_drain (cfg_open_drain),
    .line_o         (line_o),
    .line_oe        (line_oe),
    .busy           (busy),
    .cmd_done       (cmd_done)
);

// File: tb/sim_mmc_cmdline_seq.sv
`timescale 1ns/1ps
module sim_mmc_cmdline_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        card_ce = 1'b0;
    logic        cfg_init = 1'b0;
    logic        cfg_host_resp = 1'b0;
    logic        cfg_ceata = 1'b0;
    logic        cfg_open_drain = 1'b0;
    logic [31:0] arg_in = '0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic        line_o, line_oe, busy, cmd_done;

    int n_chk = 0;
    int n_fail = 0;
    int ce_div = 1;
    int ce_cnt = 0;
    int done_cnt = 0;
    bit exp_q[$];
    string tag_q[$];
    bit prev_busy = 0;
    bit prev_ce = 0;
    bit prev_line = 1;

    always #4 clk = ~clk;

    mmc_cmdline_seq u0 (
        .clk(clk), .rst_n(rst_n), .card_ce(card_ce), .cfg_init(cfg_init),
        .cfg_host_resp(cfg_host_resp), .cfg_ceata(cfg_ceata),
        .cfg_open_drain(cfg_open_drain), .arg_in(arg_in), .cmd_wr(cmd_wr),
        .cmd_wdata(cmd_wdata), .line_o(line_o), .line_oe(line_oe),
        .busy(busy), .cmd_done(cmd_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Card clock enable generator
    always @(posedge clk) begin
        #1;
        card_ce = (ce_cnt == 0);
        ce_cnt  = (ce_cnt + 1 >= ce_div) ? 0 : ce_cnt + 1;
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            bit res;
            res = line_oe ? line_o : 1'b1;
            if (busy && card_ce) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8", "unexpected bit while busy", res, -1);
                end else begin
                    bit e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(res == e, t, "line bit", res, e);
                    if (cfg_open_drain)
                        check(line_oe == !e, "R7", "open-drain enable", line_oe, !e);
                    else
                        check(line_oe == 1'b1, "R7", "push-pull enable", line_oe, 1);
                end
            end
            if (busy && prev_busy && !prev_ce)
                check(res == prev_line, "R9", "line held without enable", res, prev_line);
            if (cmd_done) begin
                done_cnt++;
                check(busy == 1'b0, "R3", "busy in done cycle", busy, 0);
                check(exp_q.size() == 0, "R3", "bits left at done", exp_q.size(), 0);
            end
            prev_busy = busy;
            prev_ce   = card_ce;
            prev_line = res;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic push_n(input bit v, input int n, input string t);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(v);
            tag_q.push_back(t);
        end
    endtask

    function automatic bit [6:0] ref_crc7(input bit [39:0] d);
        bit [6:0] r = '0;
        for (int i = 39; i >= 0; i--) begin
            bit top;
            top = r[6] ^ d[i];
            r = r << 1;
            if (top) r = r ^ 7'b0001001;
        end
        return r;
    endfunction

    task automatic push_frame(input bit [5:0] idx, input bit [31:0] a);
        bit [47:0] f;
        f = {2'b00, idx, a, ref_crc7({2'b00, idx, a}), 1'b1};
        for (int i = 47; i >= 0; i--) begin
            exp_q.push_back(f[i]);
            tag_q.push_back((i >= 1 && i <= 7) ? "R6" : "R5");
        end
    endtask

    task automatic wait_done(input int target, input string req);
        int guard = 0;
        while (done_cnt < target && guard < 5000) begin
            tick(1);
            guard++;
        end
        check(done_cnt == target, req, "completion count", done_cnt, target);
    endtask

    task automatic check_idle(input int n, input string req);
        tick(n);
        check(busy == 1'b0, req, "busy after idle wait", busy, 0);
        check(line_oe == 1'b0, req, "enable after idle wait", line_oe, 0);
        check(exp_q.size() == 0, req, "pending bits", exp_q.size(), 0);
    endtask

    task automatic pulse_wr(input bit [15:0] d);
        cmd_wdata = d;
        cmd_wr = 1'b1;
        tick(1);
        cmd_wr = 1'b0;
    endtask

    initial begin
        int target;
        target = 0;
        tick(3);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0, "R1", "reset busy", busy, 0);
        check(cmd_done == 0, "R1", "reset done", cmd_done, 0);
        check(line_oe == 0, "R1", "reset enable", line_oe, 0);
        check(line_o == 1, "R1", "reset line", line_o, 1);
        tick(1);

        // R2: init stream, push-pull, enable every cycle
        ce_div = 1;
        push_n(1'b1, 80, "R2");
        cfg_init = 1'b1;
        tick(1);
        target++;
        wait_done(target, "R2");
        cfg_init = 1'b0;
        check_idle(5, "R2");

        // R2/R7/R9: init stream, open drain, slow enable
        ce_div = 3;
        cfg_open_drain = 1'b1;
        push_n(1'b1, 80, "R2");
        cfg_init = 1'b1;
        tick(1);
        target++;
        wait_done(target, "R2");
        cfg_init = 1'b0;
        check_idle(5, "R2");

        // R4: disable token
        ce_div = 2;
        cfg_ceata = 1'b1;
        cfg_host_resp = 1'b1;
        arg_in = '0;
        push_n(1'b0, 47, "R4");
        push_n(1'b1, 1, "R4");
        pulse_wr(16'h0000);
        target++;
        wait_done(target, "R4");
        check_idle(5, "R4");

        // R5/R6: host response frame, open drain
        ce_div = 1;
        cfg_ceata = 1'b0;
        arg_in = 32'hDEADBEEF;
        push_frame(6'h28, 32'hDEADBEEF);
        pulse_wr(16'h0028);
        target++;
        wait_done(target, "R5");
        check_idle(5, "R5");

        // R5/R6/R7: another frame, push-pull, slow enable
        ce_div = 4;
        cfg_open_drain = 1'b0;
        arg_in = 32'h12345678;
        push_frame(6'h3F, 32'h12345678);
        pulse_wr(16'hFF3F);
        target++;
        wait_done(target, "R6");
        check_idle(5, "R6");

        // R8: requests during a running stream are ignored
        ce_div = 2;
        cfg_open_drain = 1'b1;
        push_n(1'b1, 80, "R8");
        cfg_init = 1'b1;
        tick(1);
        tick(20);
        cfg_init = 1'b0;
        pulse_wr(16'h0011);
        tick(10);
        cfg_init = 1'b1;
        tick(3);
        target++;
        wait_done(target, "R8");
        check_idle(40, "R8");
        check(done_cnt == target, "R8", "extra completion", done_cnt, target);
        cfg_init = 1'b0;
        tick(2);

        // R10: writes that must start nothing
        cfg_host_resp = 1'b0;
        cfg_ceata = 1'b0;
        pulse_wr(16'h0005);
        check_idle(10, "R10");
        cfg_host_resp = 1'b1;
        cfg_ceata = 1'b1;
        arg_in = 32'h00000001;
        pulse_wr(16'h0000);
        check_idle(10, "R10");
        arg_in = '0;
        pulse_wr(16'h0002);
        check_idle(10, "R10");
        check(done_cnt == target, "R10", "spurious completion", done_cnt, target);

        // R11: init edge and response write in the same cycle
        cfg_ceata = 1'b0;
        ce_div = 1;
        push_n(1'b1, 80, "R11");
        cfg_init = 1'b1;
        cmd_wdata = 16'h0015;
        cmd_wr = 1'b1;
        tick(1);
        cmd_wr = 1'b0;
        target++;
        wait_done(target, "R11");
        check_idle(60, "R11");
        cfg_init = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule